// File: doc/BRIEF.md
# Register Scoreboard with Dependent Wakeup

This block tracks, for every physical register, whether its value has been produced, and for every instruction window slot, which of that instruction's source operands are still outstanding. An instruction is inserted into a slot with its source register indices, a per-source "unready at rename" flag, and an optional destination. Sources flagged unready are checked again against the scoreboard when they arrive. This catches producers that completed while the instruction was travelling from rename. Sources that are still outstanding keep the slot in the waiting set.

A writeback names one destination register. It marks that register ready and clears the matching pending operand of every waiting slot. When a slot's last pending operand clears, the block pulses that slot's bit on a ready vector, and the slot leaves the waiting set. A squash names a thread and a sequence number. It drops the waiting slots of that thread that are younger than the number, and it emits no ready pulse for them. Register indices at or above the physical register count are never tracked.

Top module: `regscore_wakeup`

## Requirements
- R1: After reset every scoreboard bit is 0 (not ready), no slot is waiting, and no ready or error pulse is raised.
- R2: On insertion, a source whose unready flag is 1, whose index is in range and whose scoreboard bit is 0 makes the slot wait on that register (its bit in `wait_mask` is 1 the next cycle). A source whose flag is 0, or whose scoreboard bit is 1, counts as ready at once.
- R3: A source or destination index at or above NUM_PREGS is never waited on. A writeback or insertion with such an index changes no scoreboard bit.
- R4: Inserting an instruction with a valid in-range destination clears that register's scoreboard bit at the next edge. This clear wins over a writeback to the same register in the same cycle.
- R5: A writeback to an in-range register sets its scoreboard bit and wakes every pending source of every waiting slot that names that register, including two sources of one slot.
- R6: `err` pulses one cycle after an insertion whose valid destination still has waiting sources attached, unless a writeback to that register occurs in the same cycle.
- R7: `rdy_mask` bit i pulses for exactly one cycle, one cycle after slot i's last pending source is woken, or one cycle after slot i is inserted with no pending source. A slot that pulses is no longer in `wait_mask`.
- R8: A source whose register is written back in the same cycle as the insertion counts as ready.
- R9: A squash removes the waiting slots whose thread equals `sq_tid` and whose sequence number is greater than `sq_seq` (unsigned), with no ready pulse. Squash wins over a wakeup in the same cycle. Other slots are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_slot | input | SLOT_W | Window slot receiving the instruction |
| ins_tid | input | TID_W | Thread of the inserted instruction |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_src | input | NUM_SRC*PREG_W | Source register indices, source s at bits [s*PREG_W +: PREG_W] |
| ins_src_unready | input | NUM_SRC | Bit s is 1 when rename saw source s as not yet produced |
| ins_has_dst | input | 1 | Inserted instruction writes a destination |
| ins_dst | input | PREG_W | Destination register index |
| wb_valid | input | 1 | A producer completes this cycle |
| wb_dst | input | PREG_W | Register written by the completing producer |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Slots with a larger sequence number are removed |
| reg_ready | output | NUM_PREGS | Scoreboard, bit r set when register r is ready |
| wait_mask | output | NUM_SLOTS | Slots that still wait on at least one source |
| rdy_mask | output | NUM_SLOTS | One-cycle pulse per slot whose operands all became ready |
| err | output | 1 | Producer inserted while consumers still wait on its destination |

## Verification
The bench builds the block with 8 physical registers, 4-bit register indices, 4 slots, two sources and two threads. The wide index leaves the values 8 to 15 free to exercise the out-of-range rule, and the small window lets random traffic fill every slot and repeatedly collide writebacks, inserts and squashes on the same register and cycle. A behavioural model is compared on every clock against the scoreboard, waiting set, ready pulses and error pulse. Directed steps first cover the same-cycle priorities and two sources of one slot woken by a single writeback.

// File: rtl/regscore_wakeup.sv
module regscore_wakeup #(
  parameter int NUM_PREGS = 64,
  parameter int PREG_W    = 7,
  parameter int NUM_SLOTS = 16,
  parameter int NUM_SRC   = 2,
  parameter int SEQ_W     = 8,
  parameter int TID_W     = 1,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ins_valid,
  input  logic [SLOT_W-1:0]         ins_slot,
  input  logic [TID_W-1:0]          ins_tid,
  input  logic [SEQ_W-1:0]          ins_seq,
  input  logic [NUM_SRC*PREG_W-1:0] ins_src,
  input  logic [NUM_SRC-1:0]        ins_src_unready,
  input  logic                      ins_has_dst,
  input  logic [PREG_W-1:0]         ins_dst,
  input  logic                      wb_valid,
  input  logic [PREG_W-1:0]         wb_dst,
  input  logic                      sq_valid,
  input  logic [TID_W-1:0]          sq_tid,
  input  logic [SEQ_W-1:0]          sq_seq,
  output logic [NUM_PREGS-1:0]      reg_ready,
  output logic [NUM_SLOTS-1:0]      wait_mask,
  output logic [NUM_SLOTS-1:0]      rdy_mask,
  output logic                      err
);

  logic [NUM_PREGS-1:0] sb, wb_hit, dst_hit, sb_eff;
  logic [NUM_SLOTS-1:0] live, kill;
  logic [NUM_SRC-1:0]   pend [NUM_SLOTS];
  logic [NUM_SRC-1:0]   nxtp [NUM_SLOTS];
  logic [PREG_W-1:0]    srcr [NUM_SLOTS][NUM_SRC];
  logic [TID_W-1:0]     tidr [NUM_SLOTS];
  logic [SEQ_W-1:0]     seqr [NUM_SLOTS];
  logic [NUM_SRC-1:0]   ins_pend;
  logic                 err_n;

  assign reg_ready = sb;
  assign wait_mask = live;

  always_comb begin
    for (int r = 0; r < NUM_PREGS; r++) begin
      wb_hit[r]  = wb_valid && wb_dst == r[PREG_W-1:0];
      dst_hit[r] = ins_valid && ins_has_dst && ins_dst == r[PREG_W-1:0];
    end
    sb_eff = sb | wb_hit;
    for (int s = 0; s < NUM_SRC; s++) begin
      ins_pend[s] = 1'b0;
      for (int r = 0; r < NUM_PREGS; r++)
        if (ins_src[s*PREG_W +: PREG_W] == r[PREG_W-1:0])
          ins_pend[s] = ins_src_unready[s] && !sb_eff[r];
    end
    err_n = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      kill[i] = sq_valid && live[i] && tidr[i] == sq_tid && seqr[i] > sq_seq;
      for (int s = 0; s < NUM_SRC; s++) begin
        nxtp[i][s] = pend[i][s] && !(wb_valid && srcr[i][s] == wb_dst);
        if (live[i] && pend[i][s] && srcr[i][s] == ins_dst)
          err_n = 1'b1;
      end
    end
    err_n = err_n && ins_valid && ins_has_dst && !(wb_valid && wb_dst == ins_dst);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb       <= '0;
      live     <= '0;
      rdy_mask <= '0;
      err      <= 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        pend[i] <= '0;
        tidr[i] <= '0;
        seqr[i] <= '0;
        for (int s = 0; s < NUM_SRC; s++) srcr[i][s] <= '0;
      end
    end else begin
      sb       <= (sb | wb_hit) & ~dst_hit;
      err      <= err_n;
      rdy_mask <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (live[i]) begin
          pend[i] <= nxtp[i];
          if (kill[i]) live[i] <= 1'b0;
          else if (nxtp[i] == '0) begin
            live[i]     <= 1'b0;
            rdy_mask[i] <= 1'b1;
          end
        end
      end
      if (ins_valid) begin
        pend[ins_slot]     <= ins_pend;
        tidr[ins_slot]     <= ins_tid;
        seqr[ins_slot]     <= ins_seq;
        live[ins_slot]     <= |ins_pend;
        rdy_mask[ins_slot] <= ~|ins_pend;
        for (int s = 0; s < NUM_SRC; s++)
          srcr[ins_slot][s] <= ins_src[s*PREG_W +: PREG_W];
      end
    end
  end

  for (genvar r = 0; r < NUM_PREGS; r++) begin : g_sb_chk
    a_r5_wb_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_hit[r] && !dst_hit[r]) |=> reg_ready[r]);
    a_r4_ins_clears: assert property (@(posedge clk) disable iff (!rst_n)
      dst_hit[r] |=> !reg_ready[r]);
  end

  a_r7_pulse_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (|rdy_mask) |-> ((rdy_mask & wait_mask) == '0));

  a_r2_one_new_waiter: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> ((wait_mask & ~$past(wait_mask)) == '0));

  a_r6_err_from_insert: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_valid && ins_has_dst) |=> !err);

endmodule

// File: tb/regscore_wakeup_test.sv
module regscore_wakeup_test;
  localparam int NP = 8, PW = 4, SL = 4, NS = 2, QW = 8, TW = 1;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ins_has_dst = 0, wb_valid = 0, sq_valid = 0;
  logic [1:0] ins_slot = 0;
  logic [TW-1:0] ins_tid = 0, sq_tid = 0;
  logic [QW-1:0] ins_seq = 0, sq_seq = 0;
  logic [NS*PW-1:0] ins_src = 0;
  logic [NS-1:0] ins_src_unready = 0;
  logic [PW-1:0] ins_dst = 0, wb_dst = 0;
  logic [NP-1:0] reg_ready;
  logic [SL-1:0] wait_mask, rdy_mask;
  logic err;

  int total = 0, bad = 0;
  bit m_sb[NP];
  bit m_live[SL];
  bit m_p[SL][NS];
  int m_s[SL][NS];
  int m_t[SL], m_q[SL];
  logic [SL-1:0] e_rdy;
  logic e_err;

  regscore_wakeup #(.NUM_PREGS(NP), .PREG_W(PW), .NUM_SLOTS(SL), .NUM_SRC(NS),
    .SEQ_W(QW), .TID_W(TW)) uut (.*);

  always #2 clk = ~clk;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] sb_vec();
    logic [NP-1:0] v;
    for (int r = 0; r < NP; r++) v[r] = m_sb[r];
    return v;
  endfunction

  function automatic logic [SL-1:0] live_vec();
    logic [SL-1:0] v;
    for (int i = 0; i < SL; i++) v[i] = m_live[i];
    return v;
  endfunction

  task automatic model();
    bit np[NS];
    int d = int'(ins_dst), w = int'(wb_dst);
    e_rdy = 0;
    e_err = 0;
    if (ins_valid && ins_has_dst && !(wb_valid && w == d))
      for (int i = 0; i < SL; i++)
        for (int s = 0; s < NS; s++)
          if (m_live[i] && m_p[i][s] && m_s[i][s] == d) e_err = 1;
    for (int s = 0; s < NS; s++) begin
      int x = int'(ins_src[s*PW +: PW]);
      np[s] = ins_src_unready[s] && x < NP && !(m_sb[x < NP ? x : 0] || (wb_valid && w == x));
    end
    for (int i = 0; i < SL; i++) begin
      if (m_live[i]) begin
        bit any = 0;
        for (int s = 0; s < NS; s++) begin
          if (wb_valid && m_s[i][s] == w) m_p[i][s] = 0;
          any |= m_p[i][s];
        end
        if (sq_valid && m_t[i] == int'(sq_tid) && m_q[i] > int'(sq_seq)) m_live[i] = 0;
        else if (!any) begin
          m_live[i] = 0;
          e_rdy[i] = 1;
        end
      end
    end
    if (wb_valid && w < NP) m_sb[w] = 1;
    if (ins_valid && ins_has_dst && d < NP) m_sb[d] = 0;
    if (ins_valid) begin
      int k = int'(ins_slot);
      bit any = 0;
      for (int s = 0; s < NS; s++) begin
        m_p[k][s] = np[s];
        m_s[k][s] = int'(ins_src[s*PW +: PW]);
        any |= np[s];
      end
      m_t[k] = int'(ins_tid);
      m_q[k] = int'(ins_seq);
      m_live[k] = any;
      e_rdy[k] = !any;
    end
  endtask

  task automatic go();
    model();
    @(posedge clk);
    @(negedge clk);
    chk(reg_ready === sb_vec(), "R4/R5 scoreboard", 64'(reg_ready), 64'(sb_vec()));
    chk(wait_mask === live_vec(), "R2/R9 wait_mask", 64'(wait_mask), 64'(live_vec()));
    chk(rdy_mask === e_rdy, "R7 rdy_mask", 64'(rdy_mask), 64'(e_rdy));
    chk(err === e_err, "R6 err", 64'(err), 64'(e_err));
    ins_valid = 0; wb_valid = 0; sq_valid = 0;
  endtask

  task automatic ins(int slot, int tid, int seq, int s0, int s1, int unr, int dst, bit hasd);
    ins_valid = 1; ins_slot = 2'(slot); ins_tid = TW'(tid); ins_seq = QW'(seq);
    ins_src = {PW'(s1), PW'(s0)}; ins_src_unready = NS'(unr);
    ins_dst = PW'(dst); ins_has_dst = hasd;
  endtask

  task automatic wb(int r);
    wb_valid = 1; wb_dst = PW'(r);
  endtask

  task automatic sq(int t, int q);
    sq_valid = 1; sq_tid = TW'(t); sq_seq = QW'(q);
  endtask

  initial begin
    #20000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(reg_ready == 0 && wait_mask == 0 && rdy_mask == 0 && err == 0,
        "R1 reset state", 64'({reg_ready, wait_mask, rdy_mask, err}), 0);

    ins(0, 0, 1, 3, 5, 3, 6, 1); go();
    chk(wait_mask == 4'b0001, "R2 slot0 waits", 64'(wait_mask), 1);
    wb(3); go();
    chk(reg_ready == 8'h08 && wait_mask == 4'b0001, "R5 one of two woken",
        64'({reg_ready, wait_mask}), 64'({8'h08, 4'b0001}));
    wb(5); go();
    chk(rdy_mask == 4'b0001 && wait_mask == 0, "R7 pulse on last source",
        64'({rdy_mask, wait_mask}), 64'({4'b0001, 4'b0}));
    ins(1, 0, 2, 3, 12, 3, 14, 1); go();
    chk(rdy_mask == 4'b0010 && reg_ready == 8'h28, "R3 out-of-range src/dst ignored",
        64'({rdy_mask, reg_ready}), 64'({4'b0010, 8'h28}));
    wb(13); go();
    chk(reg_ready == 8'h28, "R3 out-of-range writeback", 64'(reg_ready), 64'h28);
    ins(2, 0, 3, 7, 7, 3, 1, 1); wb(7); go();
    chk(rdy_mask == 4'b0100 && reg_ready == 8'hA8, "R8 same-cycle wakeup",
        64'({rdy_mask, reg_ready}), 64'({4'b0100, 8'hA8}));
    ins(2, 0, 4, 1, 1, 3, 0, 1); go();
    wb(1); go();
    chk(rdy_mask == 4'b0100 && reg_ready == 8'hAA, "R5 both sources of one slot",
        64'({rdy_mask, reg_ready}), 64'({4'b0100, 8'hAA}));
    ins(0, 0, 10, 2, 4, 3, 0, 0); go();
    ins(1, 1, 20, 2, 0, 3, 0, 0); go();
    ins(3, 0, 5, 2, 0, 3, 0, 0); go();
    ins(2, 0, 30, 0, 0, 0, 2, 1); go();
    chk(err == 1 && rdy_mask == 4'b0100, "R6 producer over waiters",
        64'({err, rdy_mask}), 64'({1'b1, 4'b0100}));
    sq(0, 7); go();
    chk(wait_mask == 4'b1010 && rdy_mask == 0, "R9 squash younger of thread",
        64'({wait_mask, rdy_mask}), 64'({4'b1010, 4'b0}));
    wb(2); sq(1, 19); go();
    chk(wait_mask == 4'b1000 && rdy_mask == 0, "R9 squash beats wakeup",
        64'({wait_mask, rdy_mask}), 64'({4'b1000, 4'b0}));
    wb(0); go();
    chk(rdy_mask == 4'b1000 && reg_ready == 8'hAF, "R7 slot3 ready",
        64'({rdy_mask, reg_ready}), 64'({4'b1000, 8'hAF}));
    ins(0, 0, 40, 0, 0, 0, 3, 1); wb(3); go();
    chk(reg_ready == 8'hA7, "R4 insert clear beats writeback", 64'(reg_ready), 64'hA7);
    ins(0, 0, 41, 0, 0, 0, 5, 1); go();
    chk(reg_ready == 8'h87, "R4 insert clears", 64'(reg_ready), 64'h87);

    for (int n = 0; n < 600; n++) begin
      int k = $urandom_range(SL-1);
      if ($urandom_range(1) == 1 && !m_live[k])
        ins(k, $urandom_range(1), $urandom_range(255), $urandom_range(9),
            $urandom_range(9), $urandom_range(3), $urandom_range(9), 1'($urandom_range(1)));
      if ($urandom_range(4) < 2) wb($urandom_range(9));
      if ($urandom_range(9) == 0) sq($urandom_range(1), $urandom_range(255));
      go();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule